// File: doc/BRIEF.md
# UART Receive FIFO Trigger and Character Timeout Control

This block is the control logic that sits next to the receive FIFO of a UART. Software writes a byte-wide FIFO control word. That word turns FIFO mode on or off, flushes either FIFO, and picks one of four receive trigger thresholds. The FIFO storage and the serial deserializer sit outside the block. They supply the current receive occupancy, a pop strobe, a start-bit strobe and a tick that fires once per character time.

From those inputs the block raises two conditions when the occupancy reaches the chosen threshold:

- a receive-data-available condition, qualified by its interrupt enable;
- a receive DMA request, which the lowest threshold never produces.

The block also raises a character-timeout condition. This happens when bytes have sat in the FIFO for four character times and no pop or new start bit has occurred. The timeout lets software collect a short tail of data that never reaches the threshold.

Top module: `uart_rx_fifo_ctl`

## Requirements
- R1: While and after reset, with no write yet, every output is 0.
- R2: A write stores control bit 0 as the FIFO-enable output, visible from the cycle after the write. Bits 5:3 of the write data are reserved and change no output.
- R3: A write with bit 1 set gives a one-cycle rx_flush pulse in the cycle after the write. Bit 2 does the same for tx_flush. Neither bit is stored, so a later write with the bit clear gives no pulse.
- R4: Bits 7:6 select the threshold in FIFO mode. Code 00 selects 1 entry, 01 selects DEPTH/8, 10 selects DEPTH/4 and 11 selects DEPTH/2. With DEPTH 64 these are 1, 8, 16 and 32. The level is met when the occupancy is at least the threshold.
- R5: rx_avail is high exactly when the level is met and rda_irq_en is high.
- R6: rx_dma_req is high when FIFO mode is on, dma_mode is high, the level is met and the code is not 00. With code 00 it stays low at any occupancy.
- R7: With FIFO mode off, rx_avail follows occupancy of at least 1 (gated as in R5). In this mode rx_dma_req and char_timeout stay low.
- R8: In FIFO mode, with occupancy of at least 1, char_timeout rises in the cycle after the fourth character tick that follows the last clearing event. After three such ticks it is still low.
- R9: A pop, a start-bit strobe, or a control write with bit 1 set drops char_timeout in the next cycle and restarts the tick count from zero. A clearing event in the same cycle as a tick takes precedence over the tick.
- R10: Ticks that arrive while the FIFO is empty are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word write data |
| rx_count | input | CNT_W (7) | Current receive FIFO occupancy, 0 to DEPTH |
| rx_pop | input | 1 | One entry read from the receive FIFO this cycle |
| start_det | input | 1 | New start bit detected on the line |
| char_tick | input | 1 | One character time elapsed |
| rda_irq_en | input | 1 | Receive-data-available interrupt enable |
| dma_mode | input | 1 | Receive DMA operation selected |
| fifo_en | output | 1 | FIFO mode enabled |
| rx_flush | output | 1 | One-cycle receive FIFO pointer reset |
| tx_flush | output | 1 | One-cycle transmit FIFO pointer reset |
| rx_avail | output | 1 | Receive data available condition |
| rx_dma_req | output | 1 | Receive DMA request |
| char_timeout | output | 1 | Character timeout condition |

## Verification
A corrupted trigger code shows up at the next occupancy step that crosses a threshold. There, rx_avail or rx_dma_req switches at the wrong count in the same cycle that rx_count changes. A wrong idle count shows up as char_timeout rising one or more ticks early or late, or failing to drop the cycle after a pop, start bit or flush write. A stuck flush register shows as an rx_flush or tx_flush pulse that lasts more than one cycle or appears after a write with the bit clear.

// File: rtl/uart_rx_fifo_ctl_pkg.sv
package uart_rx_fifo_ctl_pkg;

    typedef enum logic [1:0] {
        TRIG_ONE     = 2'b00,
        TRIG_EIGHTH  = 2'b01,
        TRIG_QUARTER = 2'b10,
        TRIG_HALF    = 2'b11
    } trig_e;

    typedef struct packed {
        logic  fifo_en;
        trig_e trig;
    } fifo_cfg_t;

    localparam int CFG_EN_BIT     = 0;
    localparam int CFG_RXFLUSH_BIT = 1;
    localparam int CFG_TXFLUSH_BIT = 2;
    localparam int CFG_TRIG_LSB   = 6;

    function automatic fifo_cfg_t decode_cfg(input logic [7:0] w);
        fifo_cfg_t c;
        c.fifo_en = w[CFG_EN_BIT];
        c.trig    = trig_e'(w[CFG_TRIG_LSB +: 2]);
        return c;
    endfunction

endpackage

// File: rtl/uart_fifo_cfg_reg.sv
module uart_fifo_cfg_reg
    import uart_rx_fifo_ctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cfg_wr,
    input  logic [7:0] cfg_wdata,
    output fifo_cfg_t cfg,
    output logic      rx_flush,
    output logic      tx_flush,
    output logic      rx_flush_wr
);
    logic [2:0] unused_rsvd;
    assign unused_rsvd = cfg_wdata[5:3];

    assign rx_flush_wr = cfg_wr && cfg_wdata[CFG_RXFLUSH_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '0;
            rx_flush <= 1'b0;
            tx_flush <= 1'b0;
        end else begin
            rx_flush <= rx_flush_wr;
            tx_flush <= cfg_wr && cfg_wdata[CFG_TXFLUSH_BIT];
            if (cfg_wr) begin
                cfg <= decode_cfg(cfg_wdata);
            end
        end
    end
endmodule

// File: rtl/uart_rx_trigger.sv
module uart_rx_trigger
    import uart_rx_fifo_ctl_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  fifo_cfg_t        cfg,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rda_irq_en,
    input  logic             dma_mode,
    output logic             rx_avail,
    output logic             rx_dma_req
);
    localparam logic [CNT_W-1:0] THR_ONE     = CNT_W'(1);
    localparam logic [CNT_W-1:0] THR_EIGHTH  = CNT_W'(DEPTH / 8);
    localparam logic [CNT_W-1:0] THR_QUARTER = CNT_W'(DEPTH / 4);
    localparam logic [CNT_W-1:0] THR_HALF    = CNT_W'(DEPTH / 2);

    logic [CNT_W-1:0] thr;
    logic             level_met;

    always_comb begin
        if (!cfg.fifo_en) begin
            thr = THR_ONE;
        end else begin
            unique case (cfg.trig)
                TRIG_ONE:     thr = THR_ONE;
                TRIG_EIGHTH:  thr = THR_EIGHTH;
                TRIG_QUARTER: thr = THR_QUARTER;
                TRIG_HALF:    thr = THR_HALF;
                default:      thr = THR_ONE;
            endcase
        end
    end

    assign level_met  = (rx_count >= thr);
    assign rx_avail   = level_met && rda_irq_en;
    assign rx_dma_req = level_met && dma_mode && cfg.fifo_en && (cfg.trig != TRIG_ONE);
endmodule

// File: rtl/uart_rx_timeout.sv
module uart_rx_timeout #(
    parameter int CNT_W         = 7,
    parameter int TIMEOUT_CHARS = 4,
    parameter int IDLE_W        = $clog2(TIMEOUT_CHARS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_en,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_pop,
    input  logic             start_det,
    input  logic             flush_wr,
    input  logic             char_tick,
    output logic             char_timeout
);
    localparam logic [IDLE_W-1:0] IDLE_MAX = IDLE_W'(TIMEOUT_CHARS);

    logic [IDLE_W-1:0] idle_q;
    logic              restart;
    logic              has_data;

    assign has_data = (rx_count != '0);
    assign restart  = rx_pop || start_det || flush_wr || !has_data || !fifo_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_q <= '0;
        end else if (restart) begin
            idle_q <= '0;
        end else if (char_tick && (idle_q != IDLE_MAX)) begin
            idle_q <= idle_q + 1'b1;
        end
    end

    assign char_timeout = fifo_en && has_data && (idle_q == IDLE_MAX);
endmodule

// File: rtl/uart_rx_fifo_ctl.sv
module uart_rx_fifo_ctl
    import uart_rx_fifo_ctl_pkg::*;
#(
    parameter int DEPTH         = 64,
    parameter int TIMEOUT_CHARS = 4,
    parameter int CNT_W         = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [7:0]       cfg_wdata,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_pop,
    input  logic             start_det,
    input  logic             char_tick,
    input  logic             rda_irq_en,
    input  logic             dma_mode,
    output logic             fifo_en,
    output logic             rx_flush,
    output logic             tx_flush,
    output logic             rx_avail,
    output logic             rx_dma_req,
    output logic             char_timeout
);
    fifo_cfg_t cfg;
    logic      flush_wr;

    uart_fifo_cfg_reg u_cfg (
        .clk         (clk),
        .rst         (rst),
        .cfg_wr      (cfg_wr),
        .cfg_wdata   (cfg_wdata),
        .cfg         (cfg),
        .rx_flush    (rx_flush),
        .tx_flush    (tx_flush),
        .rx_flush_wr (flush_wr)
    );

    uart_rx_trigger #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_trig (
        .cfg        (cfg),
        .rx_count   (rx_count),
        .rda_irq_en (rda_irq_en),
        .dma_mode   (dma_mode),
        .rx_avail   (rx_avail),
        .rx_dma_req (rx_dma_req)
    );

    uart_rx_timeout #(.CNT_W(CNT_W), .TIMEOUT_CHARS(TIMEOUT_CHARS)) u_tmo (
        .clk          (clk),
        .rst          (rst),
        .fifo_en      (cfg.fifo_en),
        .rx_count     (rx_count),
        .rx_pop       (rx_pop),
        .start_det    (start_det),
        .flush_wr     (flush_wr),
        .char_tick    (char_tick),
        .char_timeout (char_timeout)
    );

    assign fifo_en = cfg.fifo_en;
endmodule

// File: rtl/uart_rx_fifo_ctl_chk.sv
module uart_rx_fifo_ctl_chk #(
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_wr,
    input logic [7:0]       cfg_wdata,
    input logic [CNT_W-1:0] rx_count,
    input logic             rx_pop,
    input logic             start_det,
    input logic             char_tick,
    input logic             rda_irq_en,
    input logic             fifo_en,
    input logic             rx_flush,
    input logic [1:0]       trig_code,
    input logic             rx_avail,
    input logic             rx_dma_req,
    input logic             char_timeout
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) $past(rst) |->
        !(fifo_en || rx_flush || rx_dma_req || char_timeout));

    // R3
    flush_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_wdata[1]) |=> rx_flush);

    // R5
    avail_gated_chk: assert property (@(posedge clk) disable iff (rst)
        rx_avail |-> rda_irq_en);

    // R6
    no_dma_low_code_chk: assert property (@(posedge clk) disable iff (rst)
        rx_dma_req |-> (trig_code != 2'b00 && fifo_en));

    // R8
    timeout_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(char_timeout) |-> $past(char_tick));

    // R9
    pop_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_pop || start_det) |=> !char_timeout);

    // R10
    empty_no_timeout_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_count == '0) |-> !char_timeout);
endmodule

bind uart_rx_fifo_ctl uart_rx_fifo_ctl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_wr       (cfg_wr),
    .cfg_wdata    (cfg_wdata),
    .rx_count     (rx_count),
    .rx_pop       (rx_pop),
    .start_det    (start_det),
    .char_tick    (char_tick),
    .rda_irq_en   (rda_irq_en),
    .fifo_en      (fifo_en),
    .rx_flush     (rx_flush),
    .trig_code    (cfg.trig),
    .rx_avail     (rx_avail),
    .rx_dma_req   (rx_dma_req),
    .char_timeout (char_timeout)
);

// File: tb/tb_uart_rx_fifo_ctl.sv
module tb_uart_rx_fifo_ctl;
    localparam int CNT_W = 7;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_wr = 1'b0;
    logic [7:0]       cfg_wdata = '0;
    logic [CNT_W-1:0] rx_count = '0;
    logic             rx_pop = 1'b0;
    logic             start_det = 1'b0;
    logic             char_tick = 1'b0;
    logic             rda_irq_en = 1'b0;
    logic             dma_mode = 1'b0;
    logic fifo_en, rx_flush, tx_flush, rx_avail, rx_dma_req, char_timeout;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    uart_rx_fifo_ctl dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .rx_count(rx_count), .rx_pop(rx_pop), .start_det(start_det),
        .char_tick(char_tick), .rda_irq_en(rda_irq_en), .dma_mode(dma_mode),
        .fifo_en(fifo_en), .rx_flush(rx_flush), .tx_flush(tx_flush),
        .rx_avail(rx_avail), .rx_dma_req(rx_dma_req), .char_timeout(char_timeout)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] v);
        cfg_wr = 1'b1;
        cfg_wdata = v;
        cyc();
        cfg_wr = 1'b0;
        cfg_wdata = '0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            char_tick = 1'b1;
            cyc();
            char_tick = 1'b0;
        end
    endtask

    task automatic t_reset();
        rda_irq_en = 1'b1;
        dma_mode = 1'b1;
        check("R1", "fifo_en", fifo_en, 1'b0);
        check("R1", "rx_flush", rx_flush, 1'b0);
        check("R1", "tx_flush", tx_flush, 1'b0);
        check("R1", "dma_req", rx_dma_req, 1'b0);
        check("R1", "timeout", char_timeout, 1'b0);
        check("R1", "avail empty", rx_avail, 1'b0);
        rda_irq_en = 1'b0;
        dma_mode = 1'b0;
    endtask

    task automatic t_fields();
        wr(8'h38);
        check("R2", "reserved-only write fifo_en", fifo_en, 1'b0);
        check("R2", "reserved-only write rx_flush", rx_flush, 1'b0);
        check("R2", "reserved-only write tx_flush", tx_flush, 1'b0);
        wr(8'h39);
        check("R2", "enable with reserved set", fifo_en, 1'b1);
        check("R2", "no flush from reserved", rx_flush | tx_flush, 1'b0);
    endtask

    task automatic t_flush();
        wr(8'h03);
        check("R3", "rx_flush pulse", rx_flush, 1'b1);
        check("R3", "no tx_flush", tx_flush, 1'b0);
        cyc();
        check("R3", "rx_flush one cycle", rx_flush, 1'b0);
        wr(8'h05);
        check("R3", "tx_flush pulse", tx_flush, 1'b1);
        check("R3", "no rx_flush", rx_flush, 1'b0);
        cyc();
        check("R3", "tx_flush one cycle", tx_flush, 1'b0);
        wr(8'h01);
        check("R3", "no stored flush", rx_flush | tx_flush, 1'b0);
    endtask

    task automatic t_thresholds();
        rda_irq_en = 1'b1;
        wr(8'h01);
        rx_count = 0; #1 check("R4", "code00 count0", rx_avail, 1'b0);
        rx_count = 1; #1 check("R4", "code00 count1", rx_avail, 1'b1);
        wr(8'h41);
        rx_count = 7; #1 check("R4", "code01 count7", rx_avail, 1'b0);
        rx_count = 8; #1 check("R4", "code01 count8", rx_avail, 1'b1);
        wr(8'h81);
        rx_count = 15; #1 check("R4", "code10 count15", rx_avail, 1'b0);
        rx_count = 16; #1 check("R4", "code10 count16", rx_avail, 1'b1);
        wr(8'hF9);
        rx_count = 31; #1 check("R4", "code11 count31", rx_avail, 1'b0);
        rx_count = 32; #1 check("R4", "code11 count32", rx_avail, 1'b1);
        rx_count = 64; #1 check("R4", "code11 full", rx_avail, 1'b1);
        rda_irq_en = 1'b0;
        #1 check("R5", "enable low hides avail", rx_avail, 1'b0);
        rx_count = 0;
    endtask

    task automatic t_dma();
        dma_mode = 1'b1;
        wr(8'h41);
        rx_count = 7; #1 check("R6", "dma below level", rx_dma_req, 1'b0);
        rx_count = 8; #1 check("R6", "dma at level", rx_dma_req, 1'b1);
        dma_mode = 1'b0;
        #1 check("R6", "dma mode off", rx_dma_req, 1'b0);
        dma_mode = 1'b1;
        wr(8'h01);
        rx_count = 40; #1 check("R6", "code00 no dma", rx_dma_req, 1'b0);
        rx_count = 0;
        dma_mode = 1'b0;
    endtask

    task automatic t_nonfifo();
        wr(8'hC0);
        rda_irq_en = 1'b1;
        dma_mode = 1'b1;
        rx_count = 1;
        #1 check("R7", "non-fifo avail at 1", rx_avail, 1'b1);
        check("R7", "non-fifo dma", rx_dma_req, 1'b0);
        ticks(6);
        check("R7", "non-fifo timeout", char_timeout, 1'b0);
        rda_irq_en = 1'b0;
        dma_mode = 1'b0;
        rx_count = 0;
    endtask

    task automatic t_timeout();
        wr(8'h01);
        rx_count = 3;
        ticks(3);
        check("R8", "after 3 ticks", char_timeout, 1'b0);
        ticks(1);
        check("R8", "after 4 ticks", char_timeout, 1'b1);
        ticks(2);
        check("R8", "saturated", char_timeout, 1'b1);
    endtask

    task automatic t_clears();
        rx_pop = 1'b1; cyc(); rx_pop = 1'b0;
        check("R9", "pop clears", char_timeout, 1'b0);
        ticks(3);
        check("R9", "restart 3 ticks", char_timeout, 1'b0);
        ticks(1);
        check("R9", "restart 4 ticks", char_timeout, 1'b1);
        start_det = 1'b1; char_tick = 1'b1; cyc();
        start_det = 1'b0; char_tick = 1'b0;
        check("R9", "start clears", char_timeout, 1'b0);
        ticks(3);
        check("R9", "clear beat tick", char_timeout, 1'b0);
        ticks(1);
        check("R9", "after start 4 ticks", char_timeout, 1'b1);
        wr(8'h03);
        check("R9", "flush write clears", char_timeout, 1'b0);
        cyc();
        ticks(3);
        check("R9", "after flush 3 ticks", char_timeout, 1'b0);
    endtask

    task automatic t_empty();
        rx_count = 0;
        ticks(6);
        rx_count = 2;
        #1 check("R10", "empty ticks ignored", char_timeout, 1'b0);
        ticks(3);
        check("R10", "count from zero 3", char_timeout, 1'b0);
        ticks(1);
        check("R10", "count from zero 4", char_timeout, 1'b1);
        rx_count = 0;
    endtask

    initial begin
        repeat (3) cyc();
        t_reset();
        rst = 1'b0;
        cyc();
        t_reset();
        t_fields();
        t_flush();
        t_thresholds();
        t_dma();
        t_nonfifo();
        t_timeout();
        t_clears();
        t_empty();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule